// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers every interrupt source of a 16550-style serial port and reduces them to one registered identification byte and one active-high interrupt line. Its inputs are the line-status error bits, the data-ready flag, the receive FIFO fill count and trigger level, a character-timeout pending flag, the modem-status delta bits and the transmitter events. It holds the four-bit interrupt enable register. It also holds the hidden "holding register empty" pending flag, which software clears as a side effect of reading the identification register.

Each clock the unit picks the most urgent enabled source under a fixed five-level order and registers its code in the low nibble of the identification byte. The upper bits show whether the FIFOs are enabled. Software reads the byte to learn why the line is high. The FIFOs, the shifters and the baud timing sit outside this block and feed it level and strobe signals.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt line is low, the enable register reads 0x00 and the transmit-empty pending flag is clear.
- R2: When several enabled sources are active, the reported source is the highest in this order: line status, character timeout, received data, transmit empty, modem status.
- R3: Low-nibble codes of the identification byte: 0x1 none, 0x6 line status (any of the four error/break bits with enable bit 2), 0xC character timeout, 0x4 received data, 0x2 transmit empty (enable bit 1), 0x0 modem status (any delta bit with enable bit 3).
- R4: The character-timeout source is gated by enable bit 0, the same bit that gates received data.
- R5: With FIFOs enabled, received data counts only when data-ready is set and the receive count is at least the trigger level. With FIFOs disabled, data-ready alone is enough.
- R6: The transmit-empty pending flag is set by a transmitter-empty strobe, or by an enable-register write while the holding register is empty. A set in the same cycle as a clear wins. The flag stays pending while bit 1 masks it.
- R7: The pending flag is cleared by a holding-register write strobe and by the rising edge of the identification-read signal. A read held high for many cycles clears it only once.
- R8: Identification bits 7:6 read 11 while FIFOs are enabled and 00 otherwise. Bits 5:4 keep their value, which is 00 from reset.
- R9: An enable-register write keeps only the low four bits of the written byte. Bits 7:4 of the enable output always read zero.
- R10: The identification byte and interrupt line are registered: a source change shows one clock later. The line is high exactly when the code is not 0x1, so it falls in the cycle after the last source clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| fifo_en | input | 1 | FIFOs enabled |
| line_err | input | 4 | Overrun, parity, framing and break status bits |
| data_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level in bytes |
| cto_pend | input | 1 | Character timeout pending |
| tx_empty_evt | input | 1 | Transmitter became empty (strobe) |
| thr_wr | input | 1 | Holding-register write strobe |
| thr_empty | input | 1 | Holding register is empty (level) |
| iid_rd | input | 1 | Identification-register read (level; edge-detected) |
| msr_delta | input | 4 | Modem status delta bits |
| ier_o | output | 8 | Enable register value |
| iid_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
The bench goes after the fill-count boundary one below and at the trigger level. If the compare there were off by one, the received-data code would show a byte early or a byte late. It holds a read high across a new transmitter-empty strobe: a level-sensitive clear would swallow that new interrupt. It fires a set and a clear in the same cycle. It also lets the pending flag arise while bit 1 masks it: a design that drops masked pendings would never show code 0x2 after the enable is restored. Timeout with bit 0 cleared and line errors on top of every other source test the gating and the order. A wrong gate or order would report the wrong code or raise the line when nothing is enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int N_SRC = 5;

    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_THRE  = 4'h2,
        ID_RXD   = 4'h4,
        ID_LINE  = 4'h6,
        ID_CTO   = 4'hC
    } iid_code_e;

    // Source index 0 is the most urgent.
    localparam int SRC_LINE  = 0;
    localparam int SRC_CTO   = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_THRE  = 3;
    localparam int SRC_MODEM = 4;

    function automatic iid_code_e code_of(input int idx);
        case (idx)
            SRC_LINE:  return ID_LINE;
            SRC_CTO:   return ID_CTO;
            SRC_RXD:   return ID_RXD;
            SRC_THRE:  return ID_THRE;
            default:   return ID_MODEM;
        endcase
    endfunction

    typedef struct packed {
        logic [3:0] ier;
        logic [7:0] iid;
        logic       irq;
    } prio_state_t;

    typedef struct packed {
        logic pend;
        logic rd_prev;
    } thre_state_t;

endpackage

// File: rtl/uart_irq_rxq.sv
module uart_irq_rxq #(
    parameter int CNT_W = 5
) (
    input  logic             fifo_en,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    output logic             rx_qual
);

    logic level_met;

    always_comb begin
        level_met = (rx_count >= rx_trig);
        rx_qual   = data_ready && (!fifo_en || level_met);
    end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty_evt,
    input  logic ier_wr,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic iid_rd,
    output logic pend
);
    import uart_irq_pkg::*;

    thre_state_t st_d, st_q;
    logic        rd_strobe;
    logic        set_evt;
    logic        clr_evt;

    always_comb begin
        st_d       = st_q;
        rd_strobe  = iid_rd && !st_q.rd_prev;
        set_evt    = tx_empty_evt || (ier_wr && thr_empty);
        clr_evt    = rd_strobe || thr_wr;
        st_d.rd_prev = iid_rd;
        if (set_evt) begin
            st_d.pend = 1'b1;
        end else if (clr_evt) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb (
    input  logic [uart_irq_pkg::N_SRC-1:0] src,
    output logic [3:0]                     code,
    output logic                           any
);
    import uart_irq_pkg::*;

    always_comb begin
        code = ID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src[i]) begin
                code = code_of(i);
            end
        end
        any = |src;
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             fifo_en,
    input  logic [3:0]       line_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             cto_pend,
    input  logic             tx_empty_evt,
    input  logic             thr_wr,
    input  logic             thr_empty,
    input  logic             iid_rd,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       ier_o,
    output logic [7:0]       iid_o,
    output logic             irq_o
);
    import uart_irq_pkg::*;

    localparam logic [7:0] IID_RESET = {4'h0, ID_NONE};

    prio_state_t       st_d, st_q;
    logic              thre_pend;
    logic              rx_qual;
    logic [N_SRC-1:0]  src;
    logic [3:0]        sel_code;
    logic              sel_any;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^ier_wdata[7:4];

    uart_irq_thre thre_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_empty_evt (tx_empty_evt),
        .ier_wr       (ier_wr),
        .thr_empty    (thr_empty),
        .thr_wr       (thr_wr),
        .iid_rd       (iid_rd),
        .pend         (thre_pend)
    );

    uart_irq_rxq #(.CNT_W(CNT_W)) rxq_i (
        .fifo_en    (fifo_en),
        .data_ready (data_ready),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_qual    (rx_qual)
    );

    always_comb begin
        src            = '0;
        src[SRC_LINE]  = st_q.ier[2] && (|line_err);
        src[SRC_CTO]   = st_q.ier[0] && cto_pend;
        src[SRC_RXD]   = st_q.ier[0] && rx_qual;
        src[SRC_THRE]  = st_q.ier[1] && thre_pend;
        src[SRC_MODEM] = st_q.ier[3] && (|msr_delta);
    end

    uart_irq_arb arb_i (
        .src  (src),
        .code (sel_code),
        .any  (sel_any)
    );

    always_comb begin
        st_d = st_q;
        if (ier_wr) begin
            st_d.ier = ier_wdata[3:0];
        end
        st_d.iid = {fifo_en, fifo_en, st_q.iid[5:4], sel_code};
        st_d.irq = sel_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ier <= '0;
            st_q.iid <= IID_RESET;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ier_o = {4'h0, st_q.ier};
    assign iid_o = st_q.iid;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [3:0]       line_err,
    input logic             data_ready,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] rx_trig,
    input logic             cto_pend,
    input logic             tx_empty_evt,
    input logic             thr_wr,
    input logic             thr_empty,
    input logic             ier_wr,
    input logic             thre_pend,
    input logic [7:0]       ier_o,
    input logic [7:0]       iid_o,
    input logic             irq_o
);

    // R10: line and code agree
    a_r10_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (iid_o[3:0] != 4'h1));

    // R3: only legal codes appear
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        iid_o[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

    // R9: upper enable bits never set
    a_r9_ier_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ier_o[7:4] == 4'h0);

    // R8: FIFO-enabled bits follow the enable one clock later
    a_r8_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |=> iid_o[7:6] == 2'b11);

    // R2: enabled line status wins next cycle
    a_r2_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_o[2] && (|line_err) && !ier_wr) |=> iid_o[3:0] == 4'h6);

    // R6: transmitter-empty strobe sets the pending flag
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |=> thre_pend);

    // R7: holding write clears it when no set competes
    a_r7_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !tx_empty_evt && !(ier_wr && thr_empty)) |=> !thre_pend);

    // R5: below the trigger level with FIFOs on, no received-data code
    a_r5_below_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && (rx_count < rx_trig) && !ier_wr) |=> iid_o[3:0] != 4'h4);

    // R4: timeout masked when bit 0 clear
    a_r4_cto_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_o[0] && !ier_wr) |=> iid_o[3:0] != 4'hC);

endmodule

bind uart_irq_prio uart_irq_prio_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .line_err     (line_err),
    .data_ready   (data_ready),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .cto_pend     (cto_pend),
    .tx_empty_evt (tx_empty_evt),
    .thr_wr       (thr_wr),
    .thr_empty    (thr_empty),
    .ier_wr       (ier_wr),
    .thre_pend    (thre_pend),
    .ier_o        (ier_o),
    .iid_o        (iid_o),
    .irq_o        (irq_o)
);

// File: tb/uart_irq_prio_tb.sv
`timescale 1ns/1ps
module uart_irq_prio_tb_top;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ier_wr = 0;
    logic [7:0]    ier_wdata = 0;
    logic          fifo_en = 0;
    logic [3:0]    line_err = 0;
    logic          data_ready = 0;
    logic [CW-1:0] rx_count = 0;
    logic [CW-1:0] rx_trig = 0;
    logic          cto_pend = 0;
    logic          tx_empty_evt = 0;
    logic          thr_wr = 0;
    logic          thr_empty = 0;
    logic          iid_rd = 0;
    logic [3:0]    msr_delta = 0;
    logic [7:0]    ier_o;
    logic [7:0]    iid_o;
    logic          irq_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_prio #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .fifo_en(fifo_en), .line_err(line_err), .data_ready(data_ready),
        .rx_count(rx_count), .rx_trig(rx_trig), .cto_pend(cto_pend),
        .tx_empty_evt(tx_empty_evt), .thr_wr(thr_wr), .thr_empty(thr_empty),
        .iid_rd(iid_rd), .msr_delta(msr_delta),
        .ier_o(ier_o), .iid_o(iid_o), .irq_o(irq_o)
    );

    // Behavioural reference
    int  m_ier, m_iid, m_irq;
    bit  m_thre, m_prev, m_valid;

    always @(posedge clk) begin
        int low;
        bit rd_edge;
        if (!rst_n) begin
            m_ier = 0; m_iid = 1; m_irq = 0; m_thre = 0; m_prev = 0; m_valid = 1;
        end else begin
            if ((m_ier & 4) != 0 && line_err != 0)                        low = 6;
            else if ((m_ier & 1) != 0 && cto_pend)                        low = 12;
            else if ((m_ier & 1) != 0 && data_ready &&
                     (!fifo_en || int'(rx_count) >= int'(rx_trig)))       low = 4;
            else if ((m_ier & 2) != 0 && m_thre)                          low = 2;
            else if ((m_ier & 8) != 0 && msr_delta != 0)                  low = 0;
            else                                                          low = 1;
            m_iid = (fifo_en ? 8'hC0 : 8'h00) | low;
            m_irq = (low != 1);
            rd_edge = iid_rd && !m_prev;
            m_prev  = iid_rd;
            if (rd_edge || thr_wr) m_thre = 0;
            if (tx_empty_evt || (ier_wr && thr_empty)) m_thre = 1;
            if (ier_wr) m_ier = ier_wdata % 16;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_valid && !done) begin
            chk("R10 model iid", int'(iid_o), m_iid);
            chk("R10 model irq", int'(irq_o), m_irq);
            chk("R9 model ier",  int'(ier_o), m_ier);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_ier(input logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        tick(1);
        ier_wr = 0;
        tick(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        chk("R1 iid", iid_o, 8'h01);
        chk("R1 irq", irq_o, 0);
        chk("R1 ier", ier_o, 8'h00);

        thr_empty = 1;
        wr_ier(8'hFF);
        thr_empty = 0;
        chk("R9 ier low nibble", ier_o, 8'h0F);
        chk("R6 set on enable write", iid_o, 8'h02);

        msr_delta = 4'h1; tick(2);
        chk("R2 thre over modem", iid_o, 8'h02);

        iid_rd = 1; tick(1); iid_rd = 0; tick(2);
        chk("R7 read clears", iid_o, 8'h00);
        chk("R3 modem irq", irq_o, 1);

        msr_delta = 0;
        chk("R10 irq before edge", irq_o, 1);
        tick(1);
        chk("R10 irq falls one clock later", irq_o, 0);
        chk("R10 iid none", iid_o, 8'h01);

        iid_rd = 1; tick(2);
        tx_empty_evt = 1; tick(1); tx_empty_evt = 0; tick(2);
        chk("R7 held read clears once", iid_o, 8'h02);
        iid_rd = 0; tick(2);
        chk("R7 release keeps pending", iid_o, 8'h02);
        thr_wr = 1; tick(1); thr_wr = 0; tick(2);
        chk("R7 holding write clears", iid_o, 8'h01);

        wr_ier(8'h0D);
        tx_empty_evt = 1; tick(1); tx_empty_evt = 0; tick(2);
        chk("R6 masked pending hidden", iid_o, 8'h01);
        wr_ier(8'h0F);
        chk("R6 masked pending kept", iid_o, 8'h02);
        thr_wr = 1; tick(1); thr_wr = 0; tick(2);

        fifo_en = 1; data_ready = 1; rx_trig = 4; rx_count = 3; tick(2);
        chk("R5 below trigger", iid_o, 8'hC1);
        chk("R8 fifo bits", iid_o[7:6], 2'b11);
        rx_count = 4; tick(2);
        chk("R5 at trigger", iid_o, 8'hC4);
        fifo_en = 0; rx_count = 0; tick(2);
        chk("R5 no fifo data-ready only", iid_o, 8'h04);
        chk("R8 fifo bits cleared", iid_o[7:6], 2'b00);

        cto_pend = 1; tick(2);
        chk("R2 timeout over data", iid_o, 8'h0C);
        wr_ier(8'h0E);
        chk("R4 timeout gated by bit0", iid_o, 8'h01);

        line_err = 4'b0010; tick(2);
        chk("R3 line status code", iid_o, 8'h06);
        wr_ier(8'h0F);
        chk("R2 line over all", iid_o, 8'h06);
        line_err = 0; tick(2);
        chk("R2 timeout next", iid_o, 8'h0C);
        cto_pend = 0; tick(2);
        chk("R2 data next", iid_o, 8'h04);
        data_ready = 0; tick(2);
        chk("R3 none", iid_o, 8'h01);

        thr_wr = 1; tx_empty_evt = 1; tick(1);
        thr_wr = 0; tx_empty_evt = 0; tick(2);
        chk("R6 set beats clear", iid_o, 8'h02);
        iid_rd = 1; tick(1); iid_rd = 0; tick(2);
        chk("R7 cleared again", iid_o, 8'h01);

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            ier_wr       = (r % 16) == 0;
            ier_wdata    = 8'($urandom);
            fifo_en      = (r % 64) < 40 ? fifo_en : !fifo_en;
            line_err     = ((r >> 6) % 8) == 0 ? 4'($urandom) : 4'h0;
            data_ready   = ((r >> 9) % 2) == 1;
            rx_count     = CW'((r >> 10) % 17);
            rx_trig      = CW'((r >> 15) % 15);
            cto_pend     = ((r >> 19) % 8) == 0;
            tx_empty_evt = ((r >> 22) % 8) == 0;
            thr_wr       = ((r >> 25) % 8) == 0;
            thr_empty    = ((r >> 28) % 2) == 1;
            iid_rd       = ((r >> 29) % 4) == 0 ? !iid_rd : iid_rd;
            msr_delta    = ((r >> 30) % 2) == 1 ? 4'($urandom) : 4'h0;
            tick(1);
        end
        tick(2);
        finish_run();
    end

endmodule